// File: doc/BRIEF.md
# Dual-Address UTOPIA Level 2 Receive PHY Port

This block is the receive side of a multi-PHY cell bus, seen from the physical layer. A single device answers to two bus addresses. One belongs to the fast (low-latency) channel and one to the interleaved channel, and each address is backed by its own buffer of eight 53-byte cells. Cell processing fills the buffers through a plain byte write port. The ATM-layer device polls the addresses to find out which channel has a cell waiting. It then selects a channel and pulls the cell out one byte per clock, with a flag marking the first byte.

Polling works over one shared cell-available line. The device drives that line only in the cycle after one of its own addresses has appeared on the address bus; the rest of the time the line is left to the other devices on the bus. Selection follows the usual multi-PHY rule: an address is captured while the active-low enable is high, and it takes effect when the enable drops on the next cycle. The data, start-of-cell and cell-available outputs come with separate output-enable ports so that pad cells can make them high impedance. A configuration bit turns all of these enables off at once.

Top module: `utopia2_rx_phy`

## Requirements
- R1: After reset both buffers are empty, `rx_bus_oe` and `rx_clav_oe` are 0, and `wr_ready` is 1.
- R2: When `rx_addr` equals a channel's configured address at a rising edge, `rx_clav_oe` is 1 in the following cycle and `rx_clav` is 1 exactly when that channel held at least one complete cell at that edge. An address that matches neither channel leaves `rx_clav_oe` at 0. If both configured addresses are equal, the fast channel answers.
- R3: A cell counts as stored only once all 53 of its bytes have been written. A partly written cell never makes `rx_clav` 1.
- R4: A channel becomes selected at an edge where `rx_enb_n` is 0 and the previous edge saw `rx_enb_n` at 1 with that channel's address on `rx_addr`. The selection then persists until the next such edge.
- R5: For every edge that samples `rx_enb_n` at 0 while a channel holding a cell is selected, one byte is presented in the following cycle with `rx_bus_oe` at 1. Bytes come out in the order they were written.
- R6: `rx_soc` is 1 only on byte offset 0 of each cell. After offset 52 the next byte is offset 0 of the next stored cell of that channel.
- R7: If `rx_enb_n` is 1 at an edge in the middle of a cell, `rx_bus_oe` is 0 in the following cycle. After reselection the transfer resumes at the next unread byte offset.
- R8: While a channel's cell is being transferred, polling that channel returns `rx_clav` = 1.
- R9: Each channel stores at most 8 complete cells. With 8 cells stored, `wr_ready` is 0 for that channel and a write is discarded without changing stored data.
- R10: While `cfg_hiz` is 1, `rx_bus_oe` and `rx_clav_oe` are 0 and no byte is consumed.
- R11: Selecting an address that matches neither channel makes `rx_bus_oe` 0 on the following cycles.
- R12: The two channels store and deliver independently. `wr_port` 0 is the fast channel and 1 the interleaved channel, and a full channel does not block writes to the other.
- R13: When the selected channel has no complete cell, `rx_bus_oe` stays 0 even with `rx_enb_n` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive byte clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr_fast | input | 5 | Bus address of the fast channel |
| cfg_addr_intl | input | 5 | Bus address of the interleaved channel |
| cfg_hiz | input | 1 | Forces all bus output enables off |
| wr_valid | input | 1 | Buffer write strobe |
| wr_port | input | 1 | Channel written: 0 fast, 1 interleaved |
| wr_data | input | 8 | Cell byte written, in cell order |
| wr_ready | output | 1 | Channel chosen by wr_port can accept a byte |
| rx_addr | input | 5 | Poll/select address from the ATM layer |
| rx_enb_n | input | 1 | Active-low receive enable |
| rx_data | output | 8 | Cell byte |
| rx_soc | output | 1 | First byte of cell |
| rx_bus_oe | output | 1 | Output enable for rx_data and rx_soc |
| rx_clav | output | 1 | Cell-available answer |
| rx_clav_oe | output | 1 | Output enable for rx_clav |

## Verification
The hardest state to reach is a channel that is paused in the middle of a cell, deselected, and later reselected. Only a precise sequence on the enable and address lines gets there. The bench raises `rx_enb_n` for one cycle at a chosen byte offset. Sometimes it holds the channel's own address during that cycle, so the channel is reselected. Other times it holds the unused address 31, which deselects the channel. After some other activity it reselects the channel and checks that the byte stream continues from the exact offset where it stopped. A full buffer is also driven to the wrapped write slot with a rejected write, so that any leak of the discarded byte shows up when all eight cells are read back.

// File: rtl/utopia2_rx_pkg.sv
package utopia2_rx_pkg;

  localparam int CELL_LEN = 53;

  typedef enum logic {
    CH_FAST = 1'b0,
    CH_INTL = 1'b1
  } chan_e;

  // Flat position of a byte inside a buffer of equal-sized cell slots
  function automatic int flat_index(int slot, int off, int cell_bytes);
    return slot * cell_bytes + off;
  endfunction

  // Successor of a circular index in the range 0..lim-1
  function automatic int ring_next(int v, int lim);
    return (v + 1 >= lim) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/utopia2_cell_buf.sv
module utopia2_cell_buf #(
  parameter int CELL_BYTES  = 53,
  parameter int DEPTH_CELLS = 8,
  parameter int DW          = 8,
  localparam int CNT_W      = $clog2(DEPTH_CELLS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  output logic             wr_ready,
  input  logic             rd_en,
  output logic [DW-1:0]    rd_data,
  output logic             rd_first,
  output logic             cell_avail,
  output logic [CNT_W-1:0] cell_count
);
  import utopia2_rx_pkg::*;

  localparam int SLOT_W = (DEPTH_CELLS > 1) ? $clog2(DEPTH_CELLS) : 1;
  localparam int OFF_W  = $clog2(CELL_BYTES);
  localparam int MEM_N  = CELL_BYTES * DEPTH_CELLS;
  localparam int IDX_W  = $clog2(MEM_N);

  logic [DW-1:0]     mem [MEM_N];
  logic [SLOT_W-1:0] wr_slot, rd_slot;
  logic [OFF_W-1:0]  wr_off, rd_off;
  logic [CNT_W-1:0]  count;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic              wr_fire, rd_fire, wr_last, rd_last;

  assign wr_ready   = (count < CNT_W'(DEPTH_CELLS));
  assign cell_avail = (count != '0);
  assign cell_count = count;

  assign wr_fire = wr_en && wr_ready;
  assign rd_fire = rd_en && cell_avail;
  assign wr_last = (wr_off == OFF_W'(CELL_BYTES - 1));
  assign rd_last = (rd_off == OFF_W'(CELL_BYTES - 1));

  assign wr_idx = IDX_W'(flat_index(int'(wr_slot), int'(wr_off), CELL_BYTES));
  assign rd_idx = IDX_W'(flat_index(int'(rd_slot), int'(rd_off), CELL_BYTES));

  assign rd_data  = mem[rd_idx];
  assign rd_first = (rd_off == '0);

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_slot <= '0;
      wr_off  <= '0;
    end else if (wr_fire) begin
      if (wr_last) begin
        wr_off  <= '0;
        wr_slot <= SLOT_W'(ring_next(int'(wr_slot), DEPTH_CELLS));
      end else begin
        wr_off <= wr_off + OFF_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_slot <= '0;
      rd_off  <= '0;
    end else if (rd_fire) begin
      if (rd_last) begin
        rd_off  <= '0;
        rd_slot <= SLOT_W'(ring_next(int'(rd_slot), DEPTH_CELLS));
      end else begin
        rd_off <= rd_off + OFF_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else begin
      case ({wr_fire && wr_last, rd_fire && rd_last})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/utopia2_rx_sel.sv
module utopia2_rx_sel #(
  parameter int NPORTS = 2,
  parameter int AW     = 5,
  localparam int PW    = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [AW-1:0]              rx_addr,
  input  logic                       rx_enb_n,
  input  logic [NPORTS-1:0][AW-1:0]  cfg_addr,
  input  logic [NPORTS-1:0]          cell_avail,
  output logic                       clav,
  output logic                       clav_oe,
  output logic                       act_valid,
  output logic [PW-1:0]              act_port,
  output logic                       sel_event,
  output logic                       sel_valid
);

  logic [NPORTS-1:0] hit;
  logic              hit_any;
  logic [PW-1:0]     hit_port;
  logic              enb_q, addr_hit_q, sel_valid_q, clav_q, clav_oe_q;
  logic [PW-1:0]     addr_port_q, sel_port_q;

  for (genvar p = 0; p < NPORTS; p++) begin : g_match
    assign hit[p] = (rx_addr == cfg_addr[p]);
  end

  // Lowest channel index wins when addresses coincide
  always_comb begin
    hit_any  = 1'b0;
    hit_port = '0;
    for (int p = NPORTS - 1; p >= 0; p--) begin
      if (hit[p]) begin
        hit_any  = 1'b1;
        hit_port = PW'(p);
      end
    end
  end

  assign sel_event = enb_q && !rx_enb_n;
  assign act_valid = sel_event ? addr_hit_q : sel_valid_q;
  assign act_port  = sel_event ? addr_port_q : sel_port_q;
  assign sel_valid = sel_valid_q;
  assign clav      = clav_q;
  assign clav_oe   = clav_oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enb_q       <= 1'b1;
      addr_hit_q  <= 1'b0;
      addr_port_q <= '0;
      sel_valid_q <= 1'b0;
      sel_port_q  <= '0;
      clav_q      <= 1'b0;
      clav_oe_q   <= 1'b0;
    end else begin
      enb_q       <= rx_enb_n;
      addr_hit_q  <= hit_any;
      addr_port_q <= hit_port;
      clav_oe_q   <= hit_any;
      clav_q      <= hit_any && cell_avail[hit_port];
      if (sel_event) begin
        sel_valid_q <= addr_hit_q;
        sel_port_q  <= addr_port_q;
      end
    end
  end

endmodule

// File: rtl/utopia2_rx_phy.sv
module utopia2_rx_phy #(
  parameter int AW          = 5,
  parameter int DW          = 8,
  parameter int CELL_BYTES  = 53,
  parameter int DEPTH_CELLS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_addr_fast,
  input  logic [AW-1:0] cfg_addr_intl,
  input  logic          cfg_hiz,
  input  logic          wr_valid,
  input  logic          wr_port,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  input  logic [AW-1:0] rx_addr,
  input  logic          rx_enb_n,
  output logic [DW-1:0] rx_data,
  output logic          rx_soc,
  output logic          rx_bus_oe,
  output logic          rx_clav,
  output logic          rx_clav_oe
);
  import utopia2_rx_pkg::*;

  localparam int NPORTS = 2;
  localparam int PW     = 1;
  localparam int CNT_W  = $clog2(DEPTH_CELLS + 1);

  logic [NPORTS-1:0][AW-1:0]    cfg_vec;
  logic [NPORTS-1:0]            buf_ready, buf_avail, buf_first;
  logic [NPORTS-1:0][DW-1:0]    buf_rdata;
  logic [NPORTS-1:0][CNT_W-1:0] buf_count;
  logic                         act_valid, sel_event_w, sel_valid_w, clav_w, clav_oe_w;
  logic [PW-1:0]                act_port;
  logic                         rd_fire;
  logic [CNT_W-1:0]             cnt_fast, cnt_intl;
  logic [DW-1:0]                data_q;
  logic                         soc_q, drive_q;

  assign cfg_vec[CH_FAST] = cfg_addr_fast;
  assign cfg_vec[CH_INTL] = cfg_addr_intl;

  assign wr_ready = buf_ready[wr_port];

  // A byte leaves the buffer for every sampled-low enable on a live selection
  assign rd_fire = !rx_enb_n && act_valid && buf_avail[act_port] && !cfg_hiz;

  for (genvar p = 0; p < NPORTS; p++) begin : g_chan
    utopia2_cell_buf #(
      .CELL_BYTES (CELL_BYTES),
      .DEPTH_CELLS(DEPTH_CELLS),
      .DW         (DW)
    ) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_valid && (wr_port == PW'(p))),
      .wr_data   (wr_data),
      .wr_ready  (buf_ready[p]),
      .rd_en     (rd_fire && (act_port == PW'(p))),
      .rd_data   (buf_rdata[p]),
      .rd_first  (buf_first[p]),
      .cell_avail(buf_avail[p]),
      .cell_count(buf_count[p])
    );
  end

  assign cnt_fast = buf_count[CH_FAST];
  assign cnt_intl = buf_count[CH_INTL];

  utopia2_rx_sel #(
    .NPORTS(NPORTS),
    .AW    (AW)
  ) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_addr   (rx_addr),
    .rx_enb_n  (rx_enb_n),
    .cfg_addr  (cfg_vec),
    .cell_avail(buf_avail),
    .clav      (clav_w),
    .clav_oe   (clav_oe_w),
    .act_valid (act_valid),
    .act_port  (act_port),
    .sel_event (sel_event_w),
    .sel_valid (sel_valid_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= 1'b0;
      data_q  <= '0;
      soc_q   <= 1'b0;
    end else begin
      drive_q <= rd_fire;
      if (rd_fire) begin
        data_q <= buf_rdata[act_port];
        soc_q  <= buf_first[act_port];
      end
    end
  end

  assign rx_data    = data_q;
  assign rx_soc     = soc_q && drive_q;
  assign rx_bus_oe  = drive_q && !cfg_hiz;
  assign rx_clav    = clav_w;
  assign rx_clav_oe = clav_oe_w && !cfg_hiz;

endmodule

// File: rtl/utopia2_rx_chk.sv
module utopia2_rx_chk #(
  parameter int AW          = 5,
  parameter int DEPTH_CELLS = 8,
  parameter int CNT_W       = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_hiz,
  input logic [AW-1:0]    cfg_addr_fast,
  input logic [AW-1:0]    cfg_addr_intl,
  input logic [AW-1:0]    rx_addr,
  input logic             rx_enb_n,
  input logic             rx_bus_oe,
  input logic             rx_clav_oe,
  input logic             sel_valid_w,
  input logic [CNT_W-1:0] cnt_fast,
  input logic [CNT_W-1:0] cnt_intl
);

  a_r10_force_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hiz |-> (!rx_bus_oe && !rx_clav_oe));

  a_r5_bus_after_enb: assert property (@(posedge clk) disable iff (!rst_n)
    rx_bus_oe |-> $past(!rx_enb_n));

  a_r2_clav_after_poll: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clav_oe |-> $past((rx_addr == cfg_addr_fast) || (rx_addr == cfg_addr_intl)));

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_fast <= CNT_W'(DEPTH_CELLS)) && (cnt_intl <= CNT_W'(DEPTH_CELLS)));

  a_r11_bus_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    rx_bus_oe |-> sel_valid_w);

endmodule

bind utopia2_rx_phy utopia2_rx_chk #(
  .AW         (AW),
  .DEPTH_CELLS(DEPTH_CELLS),
  .CNT_W      (CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_hiz      (cfg_hiz),
  .cfg_addr_fast(cfg_addr_fast),
  .cfg_addr_intl(cfg_addr_intl),
  .rx_addr      (rx_addr),
  .rx_enb_n     (rx_enb_n),
  .rx_bus_oe    (rx_bus_oe),
  .rx_clav_oe   (rx_clav_oe),
  .sel_valid_w  (sel_valid_w),
  .cnt_fast     (cnt_fast),
  .cnt_intl     (cnt_intl)
);

// File: tb/utopia2_rx_phy_tb.sv
module utopia2_rx_phy_tb;

  localparam int A_FAST = 3;
  localparam int A_INTL = 17;
  localparam int A_NULL = 31;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] cfg_addr_fast, cfg_addr_intl;
  logic       cfg_hiz;
  logic       wr_valid, wr_port;
  logic [7:0] wr_data;
  logic       wr_ready;
  logic [4:0] rx_addr;
  logic       rx_enb_n;
  logic [7:0] rx_data;
  logic       rx_soc, rx_bus_oe, rx_clav, rx_clav_oe;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  int wcid[2];
  int rcid[2];
  int roff[2];

  always #10 clk = ~clk;

  utopia2_rx_phy u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_addr_fast(cfg_addr_fast), .cfg_addr_intl(cfg_addr_intl), .cfg_hiz(cfg_hiz),
    .wr_valid(wr_valid), .wr_port(wr_port), .wr_data(wr_data), .wr_ready(wr_ready),
    .rx_addr(rx_addr), .rx_enb_n(rx_enb_n),
    .rx_data(rx_data), .rx_soc(rx_soc), .rx_bus_oe(rx_bus_oe),
    .rx_clav(rx_clav), .rx_clav_oe(rx_clav_oe)
  );

  function automatic logic [7:0] pat(int p, int c, int o);
    return 8'((c * 37 + o * 5 + p * 113 + 11) & 255);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic write_bytes(int p, int from, int upto);
    for (int o = from; o <= upto; o++) begin
      wr_valid = 1'b1; wr_port = p[0]; wr_data = pat(p, wcid[p], o);
      cyc();
    end
    wr_valid = 1'b0;
    if (upto == 52) wcid[p]++;
  endtask

  task automatic poll(int a, bit exp_oe, bit exp_clav, string tag);
    rx_addr = 5'(a); rx_enb_n = 1'b1;
    cyc();
    chk(rx_clav_oe == exp_oe, {tag, " clav_oe"}, int'(rx_clav_oe), int'(exp_oe));
    if (exp_oe) chk(rx_clav == exp_clav, {tag, " clav"}, int'(rx_clav), int'(exp_clav));
    rx_addr = 5'(A_NULL);
  endtask

  task automatic select(int a);
    rx_addr = 5'(a); rx_enb_n = 1'b1;
    cyc();
    rx_enb_n = 1'b0; rx_addr = 5'(A_NULL);
  endtask

  task automatic rd(int p, string tag);
    logic [7:0] e;
    cyc();
    e = pat(p, rcid[p], roff[p]);
    chk(rx_bus_oe == 1'b1, {tag, " oe"}, int'(rx_bus_oe), 1);
    chk(rx_data == e, {tag, " data"}, int'(rx_data), int'(e));
    chk(rx_soc == (roff[p] == 0), {tag, " soc"}, int'(rx_soc), int'(roff[p] == 0));
    roff[p]++;
    if (roff[p] == 53) begin roff[p] = 0; rcid[p]++; end
  endtask

  task automatic idle();
    rx_enb_n = 1'b1; rx_addr = 5'(A_NULL);
    cyc();
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_addr_fast = 5'(A_FAST); cfg_addr_intl = 5'(A_INTL); cfg_hiz = 1'b0;
    wr_valid = 1'b0; wr_port = 1'b0; wr_data = '0; rx_addr = 5'(A_NULL); rx_enb_n = 1'b1;
    for (int i = 0; i < 2; i++) begin wcid[i] = 0; rcid[i] = 0; roff[i] = 0; end
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    chk(!rx_bus_oe, "R1 bus_oe", int'(rx_bus_oe), 0);
    chk(!rx_clav_oe, "R1 clav_oe", int'(rx_clav_oe), 0);
    chk(wr_ready, "R1 wr_ready", int'(wr_ready), 1);

    // R2 sweep of all addresses, empty buffers
    for (int a = 0; a < 32; a++) poll(a, (a == A_FAST) || (a == A_INTL), 1'b0, "R2 empty sweep");

    // R3 partial cell does not count
    write_bytes(0, 0, 51);
    poll(A_FAST, 1'b1, 1'b0, "R3 partial");
    write_bytes(0, 52, 52);
    poll(A_FAST, 1'b1, 1'b1, "R3 complete");

    // R12 interleaved channel filled separately
    write_bytes(1, 0, 52);
    write_bytes(1, 0, 52);
    for (int a = 0; a < 32; a++) poll(a, (a == A_FAST) || (a == A_INTL), 1'b1, "R2 full sweep");

    // R4 R5 R6 R7 R8 fast cell with pause and mid-cell poll
    select(A_FAST);
    for (int k = 0; k < 53; k++) begin
      if (k == 20) begin
        rx_enb_n = 1'b1; rx_addr = 5'(A_FAST);
        cyc();
        chk(!rx_bus_oe, "R7 paused", int'(rx_bus_oe), 0);
        rx_enb_n = 1'b0; rx_addr = 5'(A_NULL);
      end
      if (k == 30) rx_addr = 5'(A_FAST);
      rd(0, "R5 R6 fast cell");
      if (k == 30) begin
        chk(rx_clav_oe && rx_clav, "R8 clav during transfer", int'(rx_clav), 1);
        rx_addr = 5'(A_NULL);
      end
    end
    // R13 selected channel now empty
    cyc();
    chk(!rx_bus_oe, "R13 empty selected", int'(rx_bus_oe), 0);
    idle();
    poll(A_FAST, 1'b1, 1'b0, "R2 fast drained");

    // R11 deselect mid-cell, resume later at same offset
    select(A_INTL);
    for (int k = 0; k < 3; k++) rd(1, "R12 intl start");
    rx_enb_n = 1'b1; rx_addr = 5'(A_NULL);
    cyc();
    rx_enb_n = 1'b0;
    cyc();
    chk(!rx_bus_oe, "R11 null select", int'(rx_bus_oe), 0);
    cyc();
    chk(!rx_bus_oe, "R11 null select held", int'(rx_bus_oe), 0);
    idle();
    select(A_INTL);
    for (int k = 0; k < 103; k++) rd(1, "R7 R6 intl resume");
    cyc();
    chk(!rx_bus_oe, "R13 intl empty", int'(rx_bus_oe), 0);
    idle();

    // R10 forced high impedance
    write_bytes(0, 0, 52);
    cfg_hiz = 1'b1;
    select(A_FAST);
    for (int k = 0; k < 3; k++) begin
      rx_addr = 5'(A_FAST);
      cyc();
      chk(!rx_bus_oe && !rx_clav_oe, "R10 forced off", int'(rx_bus_oe), 0);
    end
    rx_addr = 5'(A_NULL);
    cfg_hiz = 1'b0;
    for (int k = 0; k < 53; k++) rd(0, "R10 no byte lost");
    idle();

    // R9 capacity and rejected write
    for (int c = 0; c < 8; c++) write_bytes(1, 0, 52);
    wr_port = 1'b1; #1;
    chk(!wr_ready, "R9 full", int'(wr_ready), 0);
    wr_port = 1'b0; #1;
    chk(wr_ready, "R12 other channel ready", int'(wr_ready), 1);
    wr_valid = 1'b1; wr_port = 1'b1; wr_data = 8'hEE;
    cyc();
    wr_valid = 1'b0;
    poll(A_INTL, 1'b1, 1'b1, "R9 full clav");
    select(A_INTL);
    for (int k = 0; k < 8 * 53; k++) rd(1, "R9 eight cells intact");
    cyc();
    chk(!rx_bus_oe, "R9 drained", int'(rx_bus_oe), 0);
    idle();
    poll(A_INTL, 1'b1, 1'b0, "R9 drained clav");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule